// File: doc/BRIEF.md
# Cell Shunt Balancing Controller

This block decides, for each cell of a series battery string, whether that cell's bleed resistor is switched on. It receives one 12-bit voltage code per cell, a 12-bit temperature code from the resistor bank, and a charging indication. On every sample strobe it finds the lowest and highest cells. A cell is marked for bleeding when its code is above an absolute top-of-charge floor and lies more than a programmable margin above the current string minimum. The set of marked cells is held until the next strobe, so the shunt pattern does not chatter between samples.

Each marked cell's shunt output is chopped by a shared PWM with a programmable period and on-time. A warm bank switches the PWM to a shorter on-time and reports a throttle status. A hot bank turns every shunt off at once. The trip is released only when the temperature has dropped below the throttle level. The block also stops all shunts when sample strobes stop arriving. It flags a cell that stays marked for too long, and it flags a string whose spread exceeds a limit. Everything is gated by the charging input, so no energy is bled during discharge.

Top module: `cell_shunt_ctrl`

## Requirements
- R1: On a cycle with `sample_vld` high, cell i (code at `cell_v[i*12 +: 12]`, unsigned) becomes marked when its code is strictly greater than `bal_min_v` and its code minus the lowest cell code is strictly greater than `bal_diff`. The new mark applies from the next clock edge.
- R2: Marks, and the divergence flag, change only at an edge where `sample_vld` was high. They are held unchanged at every other edge.
- R3: A free-running phase counter starts at 0 after reset and counts 0 … `pwm_period`-1, then wraps. After each edge, the PWM is on while the new phase value is below the selected duty count. The selected duty is `duty_hot` while throttling and `duty_nom` otherwise. `shunt_en[i]` is registered and equals mark(i) AND charging AND on AND not tripped AND not stale, all evaluated for the state after that edge.
- R4: If `charging` was low at an edge, every `shunt_en` bit is 0 after that edge.
- R5: The trip (`overtemp`) sets when `temp_code` ≥ `temp_trip`, with a higher code meaning hotter. It stays set while `temp_code` ≥ `temp_hot`, and clears once `temp_code` < `temp_hot`. While tripped, all shunts are 0, and this applies from the same edge that sets the trip.
- R6: `throttle_active` is 1 when `temp_code` ≥ `temp_hot` and the trip is not set. While it is 1, the PWM uses `duty_hot`.
- R7: A per-cell counter counts the edges after which the cell is marked and saturates at `bal_max_time`. It is cleared after any edge where the cell is unmarked. `bal_timeout[i]` is 1 while the cell is marked and its counter equals `bal_max_time`.
- R8: On a strobe, `diverge_err` is set to whether the highest code minus the lowest code is strictly greater than `div_limit`.
- R9: An idle counter is cleared by each strobe and otherwise counts up, saturating at `wd_limit`. `data_stale` is 1 while it equals `wd_limit`, and all shunts are 0 while `data_stale` is 1.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| charging | input | 1 | String is charging; balancing allowed |
| sample_vld | input | 1 | New cell sample set present this cycle |
| cell_v | input | N_CELL*12 | Packed cell voltage codes, cell i at bits i*12 |
| temp_code | input | 12 | Resistor bank temperature code |
| bal_min_v | input | 12 | Top-of-charge floor code |
| bal_diff | input | 12 | Margin above string minimum |
| div_limit | input | 12 | Maximum allowed max-minus-min spread |
| temp_hot | input | 12 | Throttle level and trip release level |
| temp_trip | input | 12 | Trip level |
| pwm_period | input | 16 | PWM period in clock cycles |
| duty_nom | input | 16 | On-cycles per period, normal |
| duty_hot | input | 16 | On-cycles per period, throttled |
| bal_max_time | input | 20 | Marked-cycle limit before timeout |
| wd_limit | input | 16 | Idle cycles before data is stale |
| shunt_en | output | N_CELL | Shunt drive per cell |
| bal_timeout | output | N_CELL | Per-cell balancing timeout |
| diverge_err | output | 1 | String spread too large |
| throttle_active | output | 1 | Reduced duty in force |
| overtemp | output | 1 | All shunts forced off by temperature |
| data_stale | output | 1 | Sample strobes missing |

## Verification
A wrong mark would show on `shunt_en` within one PWM period of the strobe that computed it. Because marks are held between strobes, the error would then repeat every period until the next strobe. A phase counter that is off by one shifts the on-window edges of every enabled shunt at the next wrap. Thermal-state or idle-counter errors show in the very next cycle on `overtemp`, `throttle_active` or `data_stale`, and on a gated `shunt_en`. A timer error moves the `bal_timeout` edge away from the exact cycle R7 predicts.

// File: rtl/cell_bal_pkg.sv
package cell_bal_pkg;
    typedef enum logic [1:0] {
        TH_NORMAL   = 2'd0,
        TH_THROTTLE = 2'd1,
        TH_TRIP     = 2'd2
    } therm_state_e;
endpackage

// File: rtl/cell_extremes.sv
module cell_extremes #(
    parameter int N_CELL = 4,
    parameter int VW     = 12
) (
    input  logic [N_CELL*VW-1:0] cell_v,
    output logic [VW-1:0]        v_min,
    output logic [VW-1:0]        v_max
);
    always_comb begin
        v_min = cell_v[VW-1:0];
        v_max = cell_v[VW-1:0];
        for (int i = 1; i < N_CELL; i++) begin
            if (cell_v[i*VW +: VW] < v_min) v_min = cell_v[i*VW +: VW];
            if (cell_v[i*VW +: VW] > v_max) v_max = cell_v[i*VW +: VW];
        end
    end
endmodule

// File: rtl/bank_thermal.sv
module bank_thermal
    import cell_bal_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [TW-1:0] temp_code,
    input  logic [TW-1:0] temp_hot,
    input  logic [TW-1:0] temp_trip,
    output therm_state_e  state_d,
    output therm_state_e  state_q
);
    always_comb begin
        if (temp_code >= temp_trip)
            state_d = TH_TRIP;
        else if (state_q == TH_TRIP && temp_code >= temp_hot)
            state_d = TH_TRIP;
        else if (temp_code >= temp_hot)
            state_d = TH_THROTTLE;
        else
            state_d = TH_NORMAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_NORMAL;
        else        state_q <= state_d;
    end

    // R5: a trip is never released while the bank is at or above the throttle level
    assert_trip_hysteresis_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TH_TRIP && temp_code >= temp_hot) |=> (state_q == TH_TRIP));

    // R5: reaching the trip level always ends in the trip state
    assert_trip_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_code >= temp_trip) |=> (state_q == TH_TRIP));
endmodule

// File: rtl/shunt_pwm.sv
module shunt_pwm #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pwm_period,
    input  logic [PW-1:0] duty_nom,
    input  logic [PW-1:0] duty_hot,
    input  logic          hot_d,
    output logic          on_d
);
    logic [PW-1:0] phase_d, phase_q;
    logic [PW-1:0] duty_sel;
    logic          wrap;

    always_comb begin
        wrap     = ({1'b0, phase_q} + {{PW{1'b0}}, 1'b1}) >= {1'b0, pwm_period};
        phase_d  = wrap ? '0 : phase_q + 1'b1;
        duty_sel = hot_d ? duty_hot : duty_nom;
        on_d     = phase_d < duty_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // R3: phase returns to zero after the last slot of a stable period
    assert_phase_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pwm_period) && pwm_period != '0 && phase_q == pwm_period - 1'b1)
        |=> (phase_q == '0));
endmodule

// File: rtl/cell_timer.sv
module cell_timer #(
    parameter int TMR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_d,
    input  logic [TMR_W-1:0] limit,
    output logic             tmo_q
);
    logic [TMR_W-1:0] cnt_d, cnt_q;
    logic             tmo_d;

    always_comb begin
        if (!mark_d)             cnt_d = '0;
        else if (cnt_q >= limit) cnt_d = cnt_q;
        else                     cnt_d = cnt_q + 1'b1;
        tmo_d = mark_d && (cnt_d >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmo_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            tmo_q <= tmo_d;
        end
    end
endmodule

// File: rtl/cell_shunt_ctrl.sv
module cell_shunt_ctrl
    import cell_bal_pkg::*;
#(
    parameter int N_CELL = 4,
    parameter int VW     = 12,
    parameter int TW     = 12,
    parameter int PW     = 16,
    parameter int TMR_W  = 20,
    parameter int WD_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  charging,
    input  logic                  sample_vld,
    input  logic [N_CELL*VW-1:0]  cell_v,
    input  logic [TW-1:0]         temp_code,
    input  logic [VW-1:0]         bal_min_v,
    input  logic [VW-1:0]         bal_diff,
    input  logic [VW-1:0]         div_limit,
    input  logic [TW-1:0]         temp_hot,
    input  logic [TW-1:0]         temp_trip,
    input  logic [PW-1:0]         pwm_period,
    input  logic [PW-1:0]         duty_nom,
    input  logic [PW-1:0]         duty_hot,
    input  logic [TMR_W-1:0]      bal_max_time,
    input  logic [WD_W-1:0]       wd_limit,
    output logic [N_CELL-1:0]     shunt_en,
    output logic [N_CELL-1:0]     bal_timeout,
    output logic                  diverge_err,
    output logic                  throttle_active,
    output logic                  overtemp,
    output logic                  data_stale
);
    typedef struct packed {
        logic [N_CELL-1:0] mark;
        logic [N_CELL-1:0] shunt;
        logic [WD_W-1:0]   idle;
        logic              stale;
        logic              div;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [VW-1:0] v_min, v_max;
    therm_state_e  th_d, th_q;
    logic          pwm_on_d;

    cell_extremes #(.N_CELL(N_CELL), .VW(VW)) u_ext (
        .cell_v (cell_v),
        .v_min  (v_min),
        .v_max  (v_max)
    );

    bank_thermal #(.TW(TW)) u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_code (temp_code),
        .temp_hot  (temp_hot),
        .temp_trip (temp_trip),
        .state_d   (th_d),
        .state_q   (th_q)
    );

    shunt_pwm #(.PW(PW)) u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_period (pwm_period),
        .duty_nom   (duty_nom),
        .duty_hot   (duty_hot),
        .hot_d      (th_d == TH_THROTTLE),
        .on_d       (pwm_on_d)
    );

    always_comb begin
        st_d = st_q;

        if (sample_vld) begin
            for (int i = 0; i < N_CELL; i++) begin
                st_d.mark[i] = (cell_v[i*VW +: VW] > bal_min_v) &&
                               ((cell_v[i*VW +: VW] - v_min) > bal_diff);
            end
            st_d.div = (v_max - v_min) > div_limit;
        end

        if (sample_vld)              st_d.idle = '0;
        else if (st_q.idle >= wd_limit) st_d.idle = st_q.idle;
        else                         st_d.idle = st_q.idle + 1'b1;
        st_d.stale = st_d.idle >= wd_limit;

        for (int i = 0; i < N_CELL; i++) begin
            st_d.shunt[i] = st_d.mark[i] && charging && pwm_on_d &&
                            (th_d != TH_TRIP) && !st_d.stale;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_CELL; g++) begin : g_timer
        cell_timer #(.TMR_W(TMR_W)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .mark_d (st_d.mark[g]),
            .limit  (bal_max_time),
            .tmo_q  (bal_timeout[g])
        );
    end

    assign shunt_en        = st_q.shunt;
    assign diverge_err     = st_q.div;
    assign data_stale      = st_q.stale;
    assign throttle_active = (th_q == TH_THROTTLE);
    assign overtemp        = (th_q == TH_TRIP);

    // R1: a shunt may only be on for a marked cell
    assert_shunt_needs_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shunt_en & ~st_q.mark) == '0);

    // R2: marks move only after a strobe
    assert_mark_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_vld) |-> $stable(st_q.mark));

    // R4: no bleeding after a non-charging cycle
    assert_no_discharge_bleed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(charging) |-> (shunt_en == '0));

    // R5: the trip blanks every shunt
    assert_trip_blanks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp |-> (shunt_en == '0));

    // R7: timeout only reported for a marked cell
    assert_timeout_needs_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_timeout & ~st_q.mark) == '0);

    // R9: stale data blanks every shunt
    assert_stale_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_stale |-> (shunt_en == '0));
endmodule

// File: tb/cell_shunt_ctrl_tb.sv
module cell_shunt_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int VW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic charging = 1'b0;
    logic sample_vld = 1'b0;
    logic [N*VW-1:0] cell_v = '0;
    logic [11:0] temp_code = 12'd1000;
    logic [11:0] bal_min_v = 12'd3000;
    logic [11:0] bal_diff  = 12'd10;
    logic [11:0] div_limit = 12'd200;
    logic [11:0] temp_hot  = 12'd2000;
    logic [11:0] temp_trip = 12'd2400;
    logic [15:0] pwm_period = 16'd8;
    logic [15:0] duty_nom   = 16'd4;
    logic [15:0] duty_hot   = 16'd2;
    logic [19:0] bal_max_time = 20'd40;
    logic [15:0] wd_limit   = 16'd60;
    logic [N-1:0] shunt_en, bal_timeout;
    logic diverge_err, throttle_active, overtemp, data_stale;

    cell_shunt_ctrl #(.N_CELL(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .charging(charging), .sample_vld(sample_vld),
        .cell_v(cell_v), .temp_code(temp_code), .bal_min_v(bal_min_v),
        .bal_diff(bal_diff), .div_limit(div_limit), .temp_hot(temp_hot),
        .temp_trip(temp_trip), .pwm_period(pwm_period), .duty_nom(duty_nom),
        .duty_hot(duty_hot), .bal_max_time(bal_max_time), .wd_limit(wd_limit),
        .shunt_en(shunt_en), .bal_timeout(bal_timeout), .diverge_err(diverge_err),
        .throttle_active(throttle_active), .overtemp(overtemp), .data_stale(data_stale)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cells[N];

    // reference state
    int  m_mark[N], m_cnt[N], m_tmo[N], m_shunt[N];
    int  m_idle = 0, m_phase = 0;
    bit  m_trip = 0, m_thr = 0, m_div = 0, m_stale = 0;

    task automatic put_cells(input int a, input int b, input int c, input int d);
        cells[0] = a; cells[1] = b; cells[2] = c; cells[3] = d;
        for (int i = 0; i < N; i++) cell_v[i*VW +: VW] = cells[i][VW-1:0];
    endtask

    task automatic model_edge();
        int t, mn, mx, duty;
        bit on;
        t = int'(temp_code);
        m_trip = (t >= int'(temp_trip)) || (m_trip && t >= int'(temp_hot));
        m_thr  = (t >= int'(temp_hot)) && !m_trip;
        if (sample_vld) m_idle = 0;
        else if (m_idle + 1 > int'(wd_limit)) m_idle = int'(wd_limit);
        else m_idle = m_idle + 1;
        m_stale = (m_idle >= int'(wd_limit));
        if (sample_vld) begin
            mn = cells[0]; mx = cells[0];
            foreach (cells[i]) begin
                if (cells[i] < mn) mn = cells[i];
                if (cells[i] > mx) mx = cells[i];
            end
            foreach (cells[i])
                m_mark[i] = (cells[i] > int'(bal_min_v) && (cells[i] - mn) > int'(bal_diff)) ? 1 : 0;
            m_div = (mx - mn) > int'(div_limit);
        end
        foreach (m_cnt[i]) begin
            if (m_mark[i] == 0) m_cnt[i] = 0;
            else if (m_cnt[i] + 1 > int'(bal_max_time)) m_cnt[i] = int'(bal_max_time);
            else m_cnt[i] = m_cnt[i] + 1;
            m_tmo[i] = (m_mark[i] != 0 && m_cnt[i] == int'(bal_max_time)) ? 1 : 0;
        end
        m_phase = (m_phase + 1 >= int'(pwm_period)) ? 0 : m_phase + 1;
        duty = m_thr ? int'(duty_hot) : int'(duty_nom);
        on = m_phase < duty;
        foreach (m_shunt[i])
            m_shunt[i] = (m_mark[i] != 0 && charging && on && !m_trip && !m_stale) ? 1 : 0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int es, et;
        es = 0; et = 0;
        for (int i = 0; i < N; i++) begin
            es |= m_shunt[i] << i;
            et |= m_tmo[i] << i;
        end
        chk("R1 R3 R4 R5 R9 shunt_en", int'(shunt_en), es);
        chk("R7 bal_timeout", int'(bal_timeout), et);
        chk("R8 diverge_err", int'(diverge_err), int'(m_div));
        chk("R6 throttle_active", int'(throttle_active), int'(m_thr));
        chk("R5 overtemp", int'(overtemp), int'(m_trip));
        chk("R9 data_stale", int'(data_stale), int'(m_stale));
    endtask

    task automatic step(input bit vld);
        sample_vld = vld;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        sample_vld = 1'b0;
    endtask

    task automatic run(input int n, input int strobe_every);
        for (int k = 0; k < n; k++)
            step(strobe_every > 0 && (k % strobe_every) == 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (m_mark[i]) begin m_mark[i] = 0; m_cnt[i] = 0; m_tmo[i] = 0; m_shunt[i] = 0; end
        put_cells(3100, 3050, 3005, 2990);
        charging = 1'b1;
        sample_vld = 1'b1;
        // R10: outputs stay low during reset even with live inputs
        repeat (3) @(negedge clk);
        chk("R10 reset shunt_en", int'(shunt_en), 0);
        chk("R10 reset flags", int'({bal_timeout, diverge_err, throttle_active, overtemp, data_stale}), 0);
        sample_vld = 1'b0;
        rst_n = 1'b1;

        // R1 R3: three cells marked, nominal duty
        step(1);
        run(30, 20);

        // R2: new values without a strobe leave the marks alone
        put_cells(2900, 2900, 2900, 3200);
        run(12, 0);
        // R1 boundary: margin exactly bal_diff and code equal to floor
        put_cells(3100, 3010, 3000, 3000);
        run(24, 20);

        // R4: discharge blocks shunts
        charging = 1'b0;
        run(12, 6);
        charging = 1'b1;

        // R6: throttle with reduced duty
        temp_code = 12'd2100;
        run(20, 10);

        // R5: trip, then hysteresis while still warm, then release
        temp_code = 12'd2500;
        run(10, 5);
        temp_code = 12'd2200;
        run(16, 8);
        temp_code = 12'd1900;
        run(16, 8);

        // R7: cell stays marked long enough to time out, then unmarked
        put_cells(3300, 3100, 3100, 3050);
        run(60, 20);
        put_cells(3100, 3100, 3100, 3100);
        run(10, 5);

        // R8: spread over and at the limit
        put_cells(3400, 3100, 3150, 3199);
        run(10, 5);
        put_cells(3300, 3100, 3150, 3199);
        run(10, 5);

        // R9: strobes stop, data goes stale, then recovers
        put_cells(3200, 3050, 3100, 3000);
        step(1);
        run(70, 0);
        run(20, 10);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule